// File: doc/BRIEF.md
# Masked Transaction-ID Filter for Memory Performance Counters

This block sits in front of a bank of memory-controller performance counters. It watches handshakes on the read-address and write-address channels of an AXI port and compares each transaction ID with one programmed ID, under one programmed compare mask. A matching read-address handshake raises a one-cycle read strobe. A matching write-address handshake raises a one-cycle write strobe. The counter bank counts these strobes for its two filtered event codes: 0x41 for filtered reads and 0x42 for filtered writes. Every other event code ignores the filter. All counters share the one filter setting.

Software programs the filter through a small register port, with a write at offset 0x30. The low 16 bits hold the ID and the high 16 bits hold the compare mask. The mask is kept inverted: software writes the complement of the mask it thinks in. A stored 1 means the ID bit is compared, and a stored 0 means the bit is ignored.

A build parameter selects an enhanced variant. In that variant each counter also has a byte register. A byte register adds up the bytes moved by the matching transactions of its event, and counter n's register is read at offset 0x30 + 4*n. Without the enhanced variant, every read inside that window returns the filter register.

Top module: `axi_id_filter_ctr`

## Requirements
- R1: After reset the filter register is 0 (ID 0, nothing compared), every byte register is 0 and both strobes are low.
- R2: A register write to offset 0x30 loads the whole 32-bit filter word on the next clock (ID in bits 15:0, stored compare mask in bits 31:16). A write to any other offset leaves the filter unchanged.
- R3: rd_hit_stb is high for exactly the one cycle after a clock edge at which ar_valid and ar_ready are both high and ((ar_id XOR filter ID) AND stored mask) is zero; a stored mask bit of 0 ignores that ID bit.
- R4: wr_hit_stb behaves the same way for the aw_valid/aw_ready handshake and aw_id, using the same shared filter word.
- R5: A valid without ready, or a ready without valid, produces no strobe and adds no bytes.
- R6: In the enhanced variant, an enabled counter whose event code is 0x41 adds (ar_len+1) << ar_size for each matching read. An enabled counter whose event code is 0x42 adds (aw_len+1) << aw_size for each matching write. The new total is readable at 0x30 + 4*n one clock after the strobe.
- R7: A byte register does not change while its counter is disabled, or while its event code is anything other than 0x41 or 0x42.
- R8: Asserting ctr_clear[n] zeroes byte register n on the next clock, and clearing takes priority over an add in the same cycle.
- R9: Without the enhanced variant, reads at 0x30 + 4*n for every counter n return the filter word. In both variants, reads outside that window return 0. In the enhanced variant, a read at 0x30 returns counter 0's byte register, not the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | ADDR_W | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size, log2 bytes |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size, log2 bytes |
| ctr_event | input | 8*NUM_CTR | Event code of each counter, counter n in bits 8n+7:8n |
| ctr_enable | input | NUM_CTR | Counter enables |
| ctr_clear | input | NUM_CTR | Byte register clears |
| rd_hit_stb | output | 1 | Filtered read count strobe |
| wr_hit_stb | output | 1 | Filtered write count strobe |

## Verification
Every cycle, the checker enforces several rules. A strobe appears only after a real handshake on its own channel, and never without one. The filter word changes only on a write to its offset, and then takes the written value. A cleared byte register reads zero on the next cycle, and an idle counter's register holds. The value of the masked comparison, the byte arithmetic from length and size, the sharing of one filter between both channels and the read window's mapping in each variant can only be shown by the bench's scenarios. Those scenarios compare known IDs, masks and burst shapes against totals worked out by hand.

// File: rtl/axf_pkg.sv
package axf_pkg;

    localparam int REG_W   = 32;
    localparam int FIELD_W = 16;
    localparam int XFER_W  = 16;

    localparam logic [7:0] EVT_FILT_RD = 8'h41;
    localparam logic [7:0] EVT_FILT_WR = 8'h42;

    // Stored mask sits in the upper half, match ID in the lower half.
    typedef struct packed {
        logic [FIELD_W-1:0] cmp_mask;
        logic [FIELD_W-1:0] match_id;
    } filt_reg_t;

    typedef struct packed {
        filt_reg_t          filt;
        logic               rd_hit;
        logic               wr_hit;
        logic [XFER_W-1:0]  rd_bytes;
        logic [XFER_W-1:0]  wr_bytes;
    } front_state_t;

    function automatic logic [XFER_W-1:0] xfer_bytes(input logic [7:0] len,
                                                     input logic [2:0] size);
        logic [XFER_W-1:0] beats;
        beats = XFER_W'(len) + XFER_W'(1);
        return beats << size;
    endfunction

endpackage

// File: rtl/axf_id_match.sv
module axf_id_match
    import axf_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            handshake,
    input  logic [ID_W-1:0] txn_id,
    input  filt_reg_t       filt,
    output logic            hit
);

    logic [FIELD_W-1:0] id_ext;
    logic [FIELD_W-1:0] diff;

    always_comb begin
        id_ext = FIELD_W'(txn_id);
        diff   = (id_ext ^ filt.match_id) & filt.cmp_mask;
        hit    = handshake && (diff == '0);
    end

endmodule

// File: rtl/axf_byte_acc.sv
module axf_byte_acc
    import axf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [7:0]        event_code,
    input  logic              clear,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [XFER_W-1:0] rd_bytes,
    input  logic [XFER_W-1:0] wr_bytes,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] addend;

    always_comb begin
        addend = '0;
        if (enable && event_code == EVT_FILT_RD && rd_hit) addend = CNT_W'(rd_bytes);
        if (enable && event_code == EVT_FILT_WR && wr_hit) addend = CNT_W'(wr_bytes);
        cnt_d = cnt_q + addend;
        if (clear) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/axi_id_filter_ctr.sv
module axi_id_filter_ctr
    import axf_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int CNT_W    = 32,
    parameter int ID_W     = 16,
    parameter int ADDR_W   = 8,
    parameter bit ENHANCED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_wr_addr,
    input  logic [REG_W-1:0]     reg_wr_data,
    input  logic [ADDR_W-1:0]    reg_rd_addr,
    output logic [REG_W-1:0]     reg_rd_data,
    input  logic                 ar_valid,
    input  logic                 ar_ready,
    input  logic [ID_W-1:0]      ar_id,
    input  logic [7:0]           ar_len,
    input  logic [2:0]           ar_size,
    input  logic                 aw_valid,
    input  logic                 aw_ready,
    input  logic [ID_W-1:0]      aw_id,
    input  logic [7:0]           aw_len,
    input  logic [2:0]           aw_size,
    input  logic [8*NUM_CTR-1:0] ctr_event,
    input  logic [NUM_CTR-1:0]   ctr_enable,
    input  logic [NUM_CTR-1:0]   ctr_clear,
    output logic                 rd_hit_stb,
    output logic                 wr_hit_stb
);

    localparam int WIN_BASE = 'h30;
    localparam int WIN_END  = WIN_BASE + 4 * NUM_CTR;
    localparam int IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam logic [ADDR_W-1:0] FILT_ADDR = ADDR_W'(WIN_BASE);

    front_state_t st_d, st_q;
    logic         rd_match, wr_match;
    logic [NUM_CTR-1:0][CNT_W-1:0] byte_cnt;

    axf_id_match #(.ID_W(ID_W)) u_rd_match (
        .handshake (ar_valid && ar_ready),
        .txn_id    (ar_id),
        .filt      (st_q.filt),
        .hit       (rd_match)
    );

    axf_id_match #(.ID_W(ID_W)) u_wr_match (
        .handshake (aw_valid && aw_ready),
        .txn_id    (aw_id),
        .filt      (st_q.filt),
        .hit       (wr_match)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_hit   = rd_match;
        st_d.wr_hit   = wr_match;
        st_d.rd_bytes = xfer_bytes(ar_len, ar_size);
        st_d.wr_bytes = xfer_bytes(aw_len, aw_size);
        if (reg_wr_en && reg_wr_addr == FILT_ADDR)
            st_d.filt = filt_reg_t'(reg_wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_hit_stb = st_q.rd_hit;
    assign wr_hit_stb = st_q.wr_hit;

    generate
        for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
            if (ENHANCED) begin : g_acc
                axf_byte_acc #(.CNT_W(CNT_W)) u_acc (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .enable     (ctr_enable[n]),
                    .event_code (ctr_event[8*n +: 8]),
                    .clear      (ctr_clear[n]),
                    .rd_hit     (st_q.rd_hit),
                    .wr_hit     (st_q.wr_hit),
                    .rd_bytes   (st_q.rd_bytes),
                    .wr_bytes   (st_q.wr_bytes),
                    .count      (byte_cnt[n])
                );
            end else begin : g_none
                assign byte_cnt[n] = '0;
            end
        end
    endgenerate

    logic              in_win;
    logic [ADDR_W-1:0] win_off;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        in_win  = (int'(reg_rd_addr) >= WIN_BASE) && (int'(reg_rd_addr) < WIN_END)
                  && (reg_rd_addr[1:0] == 2'b00);
        win_off = reg_rd_addr - FILT_ADDR;
        rd_idx  = IDX_W'(win_off >> 2);
        reg_rd_data = '0;
        if (in_win) begin
            if (ENHANCED) reg_rd_data = REG_W'(byte_cnt[rd_idx]);
            else          reg_rd_data = REG_W'(st_q.filt);
        end
    end

endmodule

// File: rtl/axf_checker.sv
module axf_checker
    import axf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr_en,
    input logic [ADDR_W-1:0]             reg_wr_addr,
    input logic [REG_W-1:0]              reg_wr_data,
    input logic                          ar_valid,
    input logic                          ar_ready,
    input logic                          aw_valid,
    input logic                          aw_ready,
    input logic                          rd_hit_stb,
    input logic                          wr_hit_stb,
    input filt_reg_t                     filt,
    input logic [NUM_CTR-1:0]            ctr_enable,
    input logic [NUM_CTR-1:0]            ctr_clear,
    input logic [NUM_CTR-1:0][CNT_W-1:0] byte_cnt
);

    localparam logic [ADDR_W-1:0] FILT_ADDR = ADDR_W'('h30);

    a_r3_rd_stb_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_stb |-> $past(ar_valid && ar_ready));

    a_r4_wr_stb_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_stb |-> $past(aw_valid && aw_ready));

    a_r5_no_rd_hs_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_valid && ar_ready) |=> !rd_hit_stb);

    a_r5_no_wr_hs_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !(aw_valid && aw_ready) |=> !wr_hit_stb);

    a_r2_filter_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_addr == FILT_ADDR) |=> (filt == $past(reg_wr_data)));

    a_r2_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_wr_addr == FILT_ADDR) |=> $stable(filt));

    generate
        for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
            a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
                ctr_clear[n] |=> (byte_cnt[n] == '0));

            a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctr_enable[n] && !ctr_clear[n]) |=> $stable(byte_cnt[n]));
        end
    endgenerate

endmodule

bind axi_id_filter_ctr axf_checker #(
    .NUM_CTR (NUM_CTR),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_axf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .ar_valid    (ar_valid),
    .ar_ready    (ar_ready),
    .aw_valid    (aw_valid),
    .aw_ready    (aw_ready),
    .rd_hit_stb  (rd_hit_stb),
    .wr_hit_stb  (wr_hit_stb),
    .filt        (st_q.filt),
    .ctr_enable  (ctr_enable),
    .ctr_clear   (ctr_clear),
    .byte_cnt    (byte_cnt)
);

// File: tb/test_axi_id_filter_ctr.sv
module test_axi_id_filter_ctr;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CTR    = 4;
    localparam int CNT_W      = 32;
    localparam int ID_W       = 16;
    localparam int ADDR_W     = 8;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 reg_wr_en;
    logic [ADDR_W-1:0]    reg_wr_addr;
    logic [31:0]          reg_wr_data;
    logic [ADDR_W-1:0]    reg_rd_addr;
    logic [31:0]          rd_data_enh, rd_data_leg;
    logic                 ar_valid, ar_ready, aw_valid, aw_ready;
    logic [ID_W-1:0]      ar_id, aw_id;
    logic [7:0]           ar_len, aw_len;
    logic [2:0]           ar_size, aw_size;
    logic [8*NUM_CTR-1:0] ctr_event;
    logic [NUM_CTR-1:0]   ctr_enable, ctr_clear;
    logic                 rd_stb_enh, wr_stb_enh, rd_stb_leg, wr_stb_leg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_id_filter_ctr #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .ID_W(ID_W),
                        .ADDR_W(ADDR_W), .ENHANCED(1'b1)) i_axi_id_filter_ctr (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(rd_data_enh),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
        .ar_size(ar_size), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .aw_len(aw_len), .aw_size(aw_size), .ctr_event(ctr_event),
        .ctr_enable(ctr_enable), .ctr_clear(ctr_clear),
        .rd_hit_stb(rd_stb_enh), .wr_hit_stb(wr_stb_enh)
    );

    axi_id_filter_ctr #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .ID_W(ID_W),
                        .ADDR_W(ADDR_W), .ENHANCED(1'b0)) i_axi_id_filter_ctr_legacy (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(rd_data_leg),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
        .ar_size(ar_size), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .aw_len(aw_len), .aw_size(aw_size), .ctr_event(ctr_event),
        .ctr_enable(ctr_enable), .ctr_clear(ctr_clear),
        .rd_hit_stb(rd_stb_leg), .wr_hit_stb(wr_stb_leg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = addr; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] addr, output logic [31:0] enh, output logic [31:0] leg);
        reg_rd_addr = addr;
        #1;
        enh = rd_data_enh;
        leg = rd_data_leg;
    endtask

    // One address handshake; checks the strobe in the cycle after it and
    // returns once any byte update has landed.
    task automatic xfer(input string tag, input bit is_wr, input logic [15:0] id,
                        input logic [7:0] len, input logic [2:0] size, input bit exp_hit);
        @(negedge clk);
        if (is_wr) begin
            aw_valid = 1'b1; aw_ready = 1'b1; aw_id = id; aw_len = len; aw_size = size;
        end else begin
            ar_valid = 1'b1; ar_ready = 1'b1; ar_id = id; ar_len = len; ar_size = size;
        end
        @(negedge clk);
        ar_valid = 1'b0; aw_valid = 1'b0;
        check({tag, " strobe (enh)"}, {31'd0, is_wr ? wr_stb_enh : rd_stb_enh}, {31'd0, exp_hit});
        check({tag, " strobe (legacy)"}, {31'd0, is_wr ? wr_stb_leg : rd_stb_leg}, {31'd0, exp_hit});
        check({tag, " other channel quiet"}, {31'd0, is_wr ? rd_stb_enh : wr_stb_enh}, 32'd0);
        @(negedge clk);
        check({tag, " strobe drops"}, {31'd0, is_wr ? wr_stb_enh : rd_stb_enh}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] e, l;
        peek(8'h30, e, l);
        check("R1 byte reg 0 after reset", e, 32'd0);
        check("R1 filter after reset", l, 32'd0);
        peek(8'h3C, e, l);
        check("R1 byte reg 3 after reset", e, 32'd0);
        check("R1 read strobe after reset", {31'd0, rd_stb_enh}, 32'd0);
        check("R1 write strobe after reset", {31'd0, wr_stb_enh}, 32'd0);
    endtask

    task automatic t_filter_reg();
        logic [31:0] e, l;
        reg_write(8'h30, 32'hFF00_1234);
        peek(8'h30, e, l);
        check("R2 filter readback", l, 32'hFF00_1234);
        check("R9 enhanced 0x30 is byte reg 0", e, 32'd0);
        peek(8'h34, e, l);
        check("R9 legacy window 0x34", l, 32'hFF00_1234);
        peek(8'h3C, e, l);
        check("R9 legacy window 0x3C", l, 32'hFF00_1234);
        peek(8'h40, e, l);
        check("R9 legacy past window", l, 32'd0);
        check("R9 enhanced past window", e, 32'd0);
        peek(8'h20, e, l);
        check("R9 legacy below window", l, 32'd0);
        reg_write(8'h34, 32'hDEAD_BEEF);
        peek(8'h30, e, l);
        check("R2 write elsewhere ignored", l, 32'hFF00_1234);
    endtask

    task automatic t_match();
        logic [31:0] e, l;
        xfer("R3 read masked match", 1'b0, 16'h12AB, 8'd0, 3'd0, 1'b1);
        xfer("R3 read compared bit differs", 1'b0, 16'h13AB, 8'd0, 3'd0, 1'b0);
        xfer("R4 write masked match", 1'b1, 16'h12FF, 8'd0, 3'd0, 1'b1);
        xfer("R4 write miss", 1'b1, 16'h0212, 8'd0, 3'd0, 1'b0);
        reg_write(8'h30, 32'hFFFF_00A5);
        xfer("R3 full compare hit", 1'b0, 16'h00A5, 8'd0, 3'd0, 1'b1);
        xfer("R3 full compare lsb miss", 1'b0, 16'h00A4, 8'd0, 3'd0, 1'b0);
        xfer("R4 shared filter write hit", 1'b1, 16'h00A5, 8'd0, 3'd0, 1'b1);
        peek(8'h34, e, l);
        check("R7 disabled counter untouched", e, 32'd0);
        reg_write(8'h30, 32'hFF00_1234);
    endtask

    task automatic t_bytes();
        logic [31:0] e, l;
        @(negedge clk);
        ctr_clear = '1;
        @(negedge clk);
        ctr_clear = '0;
        ctr_enable = 4'b0111;
        xfer("R6 read 4x4", 1'b0, 16'h12AB, 8'd3, 3'd2, 1'b1);
        xfer("R6 read 1x1", 1'b0, 16'h12CD, 8'd0, 3'd0, 1'b1);
        xfer("R6 read miss", 1'b0, 16'h5500, 8'd7, 3'd3, 1'b0);
        xfer("R6 write 16x8", 1'b1, 16'h12EE, 8'd15, 3'd3, 1'b1);
        xfer("R6 write 256x128", 1'b1, 16'h1200, 8'd255, 3'd7, 1'b1);
        peek(8'h34, e, l);
        check("R6 read bytes counter 1", e, 32'd17);
        peek(8'h38, e, l);
        check("R6 write bytes counter 2", e, 32'd32896);
        peek(8'h3C, e, l);
        check("R7 disabled counter 3", e, 32'd0);
        peek(8'h30, e, l);
        check("R7 unfiltered event counter 0", e, 32'd0);
        check("R9 legacy 0x30 still filter", l, 32'hFF00_1234);
    endtask

    task automatic t_no_handshake();
        logic [31:0] e, l;
        @(negedge clk);
        ar_valid = 1'b1; ar_ready = 1'b0; ar_id = 16'h1234; ar_len = 8'd3; ar_size = 3'd0;
        aw_valid = 1'b0; aw_ready = 1'b1; aw_id = 16'h1234; aw_len = 8'd3; aw_size = 3'd0;
        @(negedge clk);
        check("R5 valid without ready", {31'd0, rd_stb_enh}, 32'd0);
        check("R5 ready without valid", {31'd0, wr_stb_enh}, 32'd0);
        @(negedge clk);
        ar_valid = 1'b0; aw_ready = 1'b0;
        @(negedge clk);
        peek(8'h34, e, l);
        check("R5 no read bytes added", e, 32'd17);
        peek(8'h38, e, l);
        check("R5 no write bytes added", e, 32'd32896);
    endtask

    task automatic t_clear();
        logic [31:0] e, l;
        @(negedge clk);
        ar_valid = 1'b1; ar_ready = 1'b1; ar_id = 16'h1299; ar_len = 8'd1; ar_size = 3'd3;
        @(negedge clk);
        ar_valid = 1'b0;
        check("R8 hit pending", {31'd0, rd_stb_enh}, 32'd1);
        ctr_clear = 4'b0010;
        @(negedge clk);
        ctr_clear = '0;
        peek(8'h34, e, l);
        check("R8 clear beats add", e, 32'd0);
        xfer("R8 count after clear", 1'b0, 16'h1299, 8'd1, 3'd1, 1'b1);
        peek(8'h34, e, l);
        check("R8 fresh total", e, 32'd4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
        reg_rd_addr = 8'h30;
        ar_valid = 1'b0; ar_ready = 1'b0; ar_id = '0; ar_len = '0; ar_size = '0;
        aw_valid = 1'b0; aw_ready = 1'b0; aw_id = '0; aw_len = '0; aw_size = '0;
        ctr_event = {8'h41, 8'h42, 8'h41, 8'h04};
        ctr_enable = '0; ctr_clear = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_filter_reg();
        t_match();
        t_bytes();
        t_no_handshake();
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule